// File: doc/BRIEF.md
# Differential Clock Gate Controller

This block gates a set of differential clock outputs, each a true/complement pair, and parks them when one of two active-low requests arrives. One request powers the outputs down; the other stops only the outputs marked as stoppable. Each leg has its own output-enable, so a pin that is driven and a pin that is floating can both be modelled. An undriven leg reads 0, which stands for the level the line termination pulls it to.

The output clock runs at half the rate of `clk`: the true leg toggles on every `clk` edge while running, and one output period is two `clk` cycles. Both requests are asynchronous. Each passes a synchroniser and is then sampled on every rising edge of the complement leg. A new level counts only once two such samples in a row agree. Lanes park and restart only on the edge where the true leg rises, so every phase on a pin lasts at least one full `clk` cycle. A separate mode bit for each request picks whether a parked pair holds its true leg driven high or leaves both legs floating. Mode bits and the stoppable mask may change only while the matching request is inactive.

Top module: `clk_gate_ctrl`

## Requirements
- R1: A request level takes effect only after it passes a `SYNC_STAGES`-flop synchroniser and then matches on two consecutive rising edges of the complement leg. A low pulse on `stop_req_n` lasting two `clk` cycles never parks any lane.
- R2: A running lane has both enables at 1. Its true leg toggles on every `clk` edge and its complement leg is always the inverse of the true leg.
- R3: In power-down with `pd_float` = 0, each lane drives its true leg at 1 (`oe_true` = 1) and leaves the complement leg undriven (`oe_comp` = 0, `ck_comp` = 0).
- R4: In power-down with `pd_float` = 1, both legs of every lane are undriven and read 0.
- R5: When a stop is accepted, only lanes whose `stoppable` bit is 1 park. Lanes with the bit at 0 keep running.
- R6: A lane stopped with `stop_float` = 0 holds its true leg driven at 1 and its complement leg undriven at 0.
- R7: A lane stopped with `stop_float` = 1 has both legs undriven and reading 0.
- R8: A lane parks only on a `clk` edge at which its true leg rises. A lane never leaves the running state right after a high phase.
- R9: After a stop request is released, all stopped lanes resume on the same `clk` edge, 4 to 12 `clk` cycles (2 to 6 output periods) after the release. The first resumed phase is a high phase of the true leg.
- R10: While power-down is accepted, every lane shows the power-down state, even one that a stop request has also parked.
- R11: During reset every lane shows the power-down state for the current `pd_float` value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous power-down request, active low |
| stop_req_n | input | 1 | Asynchronous stop request, active low |
| pd_float | input | 1 | Power-down park mode: 0 true leg driven high, 1 both legs floating |
| stop_float | input | 1 | Stop park mode: 0 true leg driven high, 1 both legs floating |
| stoppable | input | NUM_OUT | Per-lane stop permission, 1 = lane may be stopped |
| ck_true | output | NUM_OUT | True leg level of each lane |
| ck_comp | output | NUM_OUT | Complement leg level of each lane |
| oe_true | output | NUM_OUT | Drive enable of each true leg |
| oe_comp | output | NUM_OUT | Drive enable of each complement leg |

## Verification
The bench builds the block with four lanes and a two-flop synchroniser. Four lanes are enough to split the lanes into a stopped group and a free-running group under two different stoppable masks. They also show that every stopped lane resumes on one shared edge. With two synchroniser stages, a release takes effect after 6 or 7 cycles, depending on the output phase at the moment of release. That sits inside the 4 to 12 cycle window, so both phase cases are reachable. With this setting the two-cycle glitch test also lands on exactly one debounce sample.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;
  typedef enum logic [1:0] {
    LANE_RUN  = 2'd0,
    LANE_DOWN = 2'd1,
    LANE_HALT = 2'd2
  } lane_state_e;

  typedef struct packed {
    logic oe_t;
    logic t;
    logic oe_c;
    logic c;
  } pin_drive_t;
endpackage

// File: rtl/clk_req_filter.sv
module clk_req_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter logic RST_LEVEL   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  input  logic sample,
  output logic level
);
  logic [SYNC_STAGES-1:0] chain_q;
  logic                   last_q;
  logic                   synced;

  assign synced = chain_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {SYNC_STAGES{RST_LEVEL}};
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-2:0], req_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= RST_LEVEL;
      level  <= RST_LEVEL;
    end else if (sample) begin
      last_q <= synced;
      if (synced == last_q) level <= synced;
    end
  end
endmodule

// File: rtl/clk_lane.sv
module clk_lane
  import clk_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise_pt,
  input  logic       phase,
  input  logic       down_on,
  input  logic       halt_on,
  input  logic       may_halt,
  input  logic       pd_float,
  input  logic       stop_float,
  output pin_drive_t pins
);
  lane_state_e state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LANE_DOWN;
    end else if (rise_pt) begin
      if (down_on)                  state_q <= LANE_DOWN;
      else if (halt_on && may_halt) state_q <= LANE_HALT;
      else                          state_q <= LANE_RUN;
    end
  end

  always_comb begin
    pins = '0;
    case (state_q)
      LANE_RUN: begin
        pins.oe_t = 1'b1;
        pins.t    = phase;
        pins.oe_c = 1'b1;
        pins.c    = ~phase;
      end
      LANE_DOWN: begin
        pins.oe_t = ~pd_float;
        pins.t    = ~pd_float;
      end
      LANE_HALT: begin
        pins.oe_t = ~stop_float;
        pins.t    = ~stop_float;
      end
      default: pins = '0;
    endcase
  end
endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
  import clk_gate_pkg::*;
#(
  parameter int NUM_OUT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pd_req_n,
  input  logic               stop_req_n,
  input  logic               pd_float,
  input  logic               stop_float,
  input  logic [NUM_OUT-1:0] stoppable,
  output logic [NUM_OUT-1:0] ck_true,
  output logic [NUM_OUT-1:0] ck_comp,
  output logic [NUM_OUT-1:0] oe_true,
  output logic [NUM_OUT-1:0] oe_comp
);
  logic phase_q;
  logic comp_rise;
  logic true_rise;
  logic pd_level;
  logic stop_level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  assign comp_rise = phase_q;
  assign true_rise = ~phase_q;

  clk_req_filter #(.SYNC_STAGES(SYNC_STAGES), .RST_LEVEL(1'b0)) u_pd_filt (
    .clk(clk), .rst_n(rst_n), .req_n(pd_req_n), .sample(comp_rise), .level(pd_level)
  );

  clk_req_filter #(.SYNC_STAGES(SYNC_STAGES), .RST_LEVEL(1'b1)) u_stop_filt (
    .clk(clk), .rst_n(rst_n), .req_n(stop_req_n), .sample(comp_rise), .level(stop_level)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
    pin_drive_t pins;
    clk_lane u_lane (
      .clk(clk), .rst_n(rst_n), .rise_pt(true_rise), .phase(phase_q),
      .down_on(~pd_level), .halt_on(~stop_level), .may_halt(stoppable[i]),
      .pd_float(pd_float), .stop_float(stop_float), .pins(pins)
    );
    assign oe_true[i] = pins.oe_t;
    assign ck_true[i] = pins.t;
    assign oe_comp[i] = pins.oe_c;
    assign ck_comp[i] = pins.c;
  end
endmodule

// File: rtl/clk_gate_ctrl_chk.sv
module clk_gate_ctrl_chk #(
  parameter int NUM_OUT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_OUT-1:0] ck_true,
  input logic [NUM_OUT-1:0] ck_comp,
  input logic [NUM_OUT-1:0] oe_true,
  input logic [NUM_OUT-1:0] oe_comp
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
    assert_park_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_true[i] && !oe_comp[i]) |-> ck_true[i]);
    assert_float_true_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_true[i] |-> !ck_true[i]);
    assert_float_comp_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_comp[i] |-> !ck_comp[i]);
    assert_pair_inverse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      oe_comp[i] |-> (oe_true[i] && (ck_comp[i] == !ck_true[i])));
    assert_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_comp[i] && $past(oe_comp[i])) |-> (ck_true[i] != $past(ck_true[i])));
    assert_park_after_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oe_comp[i]) |-> !$past(ck_true[i]));
    assert_resume_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_comp[i]) |-> ck_true[i]);
  end
endmodule

bind clk_gate_ctrl clk_gate_ctrl_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ck_true(ck_true), .ck_comp(ck_comp),
  .oe_true(oe_true), .oe_comp(oe_comp)
);

// File: tb/tb_clk_gate_ctrl.sv
module tb_clk_gate_ctrl;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n, pd_req_n, stop_req_n, pd_float, stop_float;
  logic [N-1:0] stoppable, ck_true, ck_comp, oe_true, oe_comp;

  always #5 clk = ~clk;

  clk_gate_ctrl #(.NUM_OUT(N), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .pd_req_n(pd_req_n), .stop_req_n(stop_req_n),
    .pd_float(pd_float), .stop_float(stop_float), .stoppable(stoppable),
    .ck_true(ck_true), .ck_comp(ck_comp), .oe_true(oe_true), .oe_comp(oe_comp)
  );

  typedef struct {
    int       lane;
    bit       run;
    bit [3:0] code;
    string    tag;
  } exp_t;

  exp_t sb[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  // expected code = {oe_true, ck_true, oe_comp, ck_comp}
  localparam bit [3:0] PARK_HI  = 4'b1100;
  localparam bit [3:0] PARK_OFF = 4'b0000;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push(input int lane, input bit run, input bit [3:0] code, input string tag);
    exp_t e;
    e.lane = lane; e.run = run; e.code = code; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic push_all(input bit [N-1:0] run_mask, input bit [3:0] code, input string tag);
    for (int l = 0; l < N; l++) push(l, run_mask[l], code, tag);
    @(negedge clk);
    @(negedge clk);
  endtask

  // monitor: pops expected items and compares against the pins
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      bit [3:0] act;
      e = sb.pop_front();
      act = {oe_true[e.lane], ck_true[e.lane], oe_comp[e.lane], ck_comp[e.lane]};
      if (e.run)
        chk(act[3] && act[1] && (act[0] == !act[2]), e.tag, act, 4'b1110);
      else
        chk(act == e.code, e.tag, act, e.code);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts edges from a release until the watched lane leaves park
  task automatic release_stop(input int lane, input bit watch_true, input int other, input string tag);
    int n = 0;
    bit on = 0;
    stop_req_n = 1'b1;
    while (!on && n < 30) begin
      @(posedge clk);
      @(negedge clk);
      n++;
      on = watch_true ? oe_true[lane] : oe_comp[lane];
    end
    chk(n >= 4 && n <= 12, {tag, " R9 latency"}, n, 6);
    chk(oe_comp[other] == 1'b1, {tag, " R9 same edge"}, oe_comp[other], 1);
    chk(ck_true[lane] == 1'b1, {tag, " R9 first phase high"}, ck_true[lane], 1);
    @(negedge clk);
    chk(ck_true[lane] == 1'b0, {tag, " R9 full high phase"}, ck_true[lane], 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pd_req_n = 1'b0; stop_req_n = 1'b1;
    pd_float = 1'b0; stop_float = 1'b0; stoppable = 4'b0101;
    wait_cyc(4);
    push_all('0, PARK_HI, "R11 reset mode0");

    rst_n = 1'b1;
    pd_req_n = 1'b1;
    wait_cyc(20);
    push_all('1, 4'b0, "R2 running");

    // two-cycle glitch on stop: must be ignored
    stop_req_n = 1'b0;
    wait_cyc(2);
    stop_req_n = 1'b1;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      chk(oe_comp == '1, "R1 glitch ignored", oe_comp, 15);
    end

    // stop, float mode 0, lanes 0 and 2 stoppable
    stop_req_n = 1'b0;
    begin
      bit prev_t = ck_true[0];
      bit prev_e = oe_comp[0];
      for (int c = 0; c < 14; c++) begin
        @(negedge clk);
        if (prev_e && !oe_comp[0])
          chk(prev_t == 1'b0, "R8 park after low phase", prev_t, 0);
        prev_t = ck_true[0];
        prev_e = oe_comp[0];
      end
    end
    push(0, 0, PARK_HI, "R6 stop mode0 lane0");
    push(2, 0, PARK_HI, "R6 stop mode0 lane2");
    push(1, 1, 4'b0, "R5 unstoppable lane1");
    push(3, 1, 4'b0, "R5 unstoppable lane3");
    wait_cyc(2);
    release_stop(0, 1'b0, 2, "mode0");
    wait_cyc(10);
    push_all('1, 4'b0, "R9 all running again");

    // stop, float mode 1, lanes 0 and 1 stoppable
    stop_float = 1'b1;
    stoppable = 4'b0011;
    wait_cyc(2);
    stop_req_n = 1'b0;
    wait_cyc(14);
    push(0, 0, PARK_OFF, "R7 stop mode1 lane0");
    push(1, 0, PARK_OFF, "R7 stop mode1 lane1");
    push(2, 1, 4'b0, "R5 unstoppable lane2");
    push(3, 1, 4'b0, "R5 unstoppable lane3");
    wait_cyc(2);

    // power-down on top of the stop
    pd_req_n = 1'b0;
    wait_cyc(14);
    push_all('0, PARK_HI, "R10 power-down over stop");
    push_all('0, PARK_HI, "R3 power-down mode0");
    pd_req_n = 1'b1;
    wait_cyc(14);
    push(0, 0, PARK_OFF, "R10 stop remains after pd lane0");
    push(3, 1, 4'b0, "R10 running after pd lane3");
    wait_cyc(2);
    release_stop(1, 1'b1, 0, "mode1");
    wait_cyc(10);

    // power-down float mode 1
    pd_float = 1'b1;
    wait_cyc(2);
    pd_req_n = 1'b0;
    wait_cyc(14);
    push_all('0, PARK_OFF, "R4 power-down mode1");
    pd_req_n = 1'b1;
    wait_cyc(14);
    push_all('1, 4'b0, "R2 running after pd");

    rst_n = 1'b0;
    wait_cyc(3);
    push_all('0, PARK_OFF, "R11 reset mode1");

    wait_cyc(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule